// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block sits between a processor load/store port and a slower word-wide memory port. It splits each 32-bit byte address into a tag, a line index and a byte offset. Each line holds a tag, a valid flag, a dirty flag and a block of data words. An access whose line is valid and whose stored tag equals the address tag completes in the cycle it is presented. Any other access holds the processor in a stall while the controller works on the line.

On a miss, a line that is dirty is first streamed out to memory word by word at its own address. The requested block is then read in, one word per memory beat. Only after the last beat are the new tag and the valid flag installed. The request then restarts and completes as a hit. Stores update only the cache and mark the line dirty. A store miss allocates the block first and then writes into it. Two free-running counters report completed hits and detected misses, so that miss rates can be measured.

Top module: `dm_wb_cache`

## Requirements
- R1: The low log2(BLOCK_BYTES) address bits are the byte offset, the next log2(LINES) bits the index, and the remaining upper bits the tag. Every refill beat addresses the requested block (upper address bits equal to the request's tag and index), word by word with the byte-in-word bits zero.
- R2: An access hits when the indexed line is valid and its stored tag equals the address tag. A hit raises `cpu_ready` in the same cycle as `cpu_req`, with no stall.
- R3: A load returns the value of the most recent store to that word address, or the memory contents if there was none, across any sequence of hits, misses and evictions.
- R4: A store hit writes only the cache. It issues no memory write beat, and it leaves the line dirty.
- R5: A miss keeps `cpu_ready` low until the refill ends. A miss reads exactly one block of WPB word beats. Each beat holds its address and direction until `mem_ack`. A clean or invalid victim causes no write beat.
- R6: A miss on a dirty line first writes all WPB words of the victim to the victim's own address, and the refill starts only after those write beats. The written data equals the values the victim held.
- R7: A store miss fetches the block, applies the store and marks the line dirty, so that a later eviction of that line writes it back.
- R8: After reset every line is invalid and both counters read zero. No memory request is made while idle, so the first access to any address misses.
- R9: `miss_count` rises by one for each detected miss. `hit_count` rises by one for each access completed without a miss. The restart that follows a refill is not counted as a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word-aligned byte address |
| cpu_wdata | input | WORD_W | Store data |
| cpu_rdata | output | WORD_W | Load data, valid while `cpu_ready` |
| cpu_ready | output | 1 | Access completes this cycle |
| mem_req | output | 1 | Memory beat requested |
| mem_we | output | 1 | 1 = write-back beat, 0 = refill beat |
| mem_addr | output | ADDR_W | Byte address of the beat's word |
| mem_wdata | output | WORD_W | Write-back data |
| mem_rdata | input | WORD_W | Refill data, valid with `mem_ack` |
| mem_ack | input | 1 | Beat completes this cycle |
| hit_count | output | CNT_W | Completed hits |
| miss_count | output | CNT_W | Detected misses |

## Verification
The bench builds the block with LINES=32 and BLOCK_BYTES=16, keeping the default 32-bit address and word. With these values, random word addresses over a 4 KB window share each index among eight tags, so conflict evictions of dirty and clean lines occur often. The same configuration reproduces the six-access miss/hit pattern exactly, and an address with a high tag (0x01FFF8AC) shows that the full 23-bit tag is decoded and that the refill beats land on its block.

// File: rtl/dm_wb_cache.sv
module dm_wb_cache #(
  parameter int ADDR_W      = 32,
  parameter int LINES       = 256,
  parameter int BLOCK_BYTES = 16,
  parameter int WORD_W      = 32,
  parameter int CNT_W       = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  localparam int OFF_W  = $clog2(BLOCK_BYTES);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int WPB    = BLOCK_BYTES / (WORD_W / 8);
  localparam int WSEL_W = $clog2(WPB);
  localparam int BSEL_W = OFF_W - WSEL_W;
  localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(WPB - 1);

  typedef enum logic [1:0] {S_LOOK, S_EVICT, S_FILL} st_t;

  st_t st;
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [WORD_W-1:0] dat_q [LINES*WPB];
  logic [LINES-1:0]  vld_q, mod_q;
  logic [WSEL_W-1:0] beat;
  logic              again;

  wire [TAG_W-1:0]  a_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
  wire [IDX_W-1:0]  a_idx  = cpu_addr[OFF_W +: IDX_W];
  wire [WSEL_W-1:0] a_wsel = cpu_addr[BSEL_W +: WSEL_W];
  wire              hit    = vld_q[a_idx] && (tag_q[a_idx] == a_tag);
  wire              last   = (beat == LAST_BEAT);
  wire              fill_ack = (st == S_FILL) && mem_ack;

  assign cpu_ready = (st == S_LOOK) && cpu_req && hit;
  assign cpu_rdata = dat_q[{a_idx, a_wsel}];
  assign mem_req   = (st != S_LOOK);
  assign mem_we    = (st == S_EVICT);
  assign mem_addr  = {(st == S_EVICT) ? tag_q[a_idx] : a_tag, a_idx, beat, {BSEL_W{1'b0}}};
  assign mem_wdata = dat_q[{a_idx, beat}];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_LOOK;
      vld_q      <= '0;
      mod_q      <= '0;
      beat       <= '0;
      again      <= 1'b0;
      hit_count  <= '0;
      miss_count <= '0;
    end else begin
      case (st)
        S_LOOK: if (cpu_req) begin
          if (hit) begin
            again <= 1'b0;
            if (!again) hit_count <= hit_count + CNT_W'(1);
            if (cpu_we) mod_q[a_idx] <= 1'b1;
          end else begin
            miss_count <= miss_count + CNT_W'(1);
            beat       <= '0;
            st         <= (vld_q[a_idx] && mod_q[a_idx]) ? S_EVICT : S_FILL;
          end
        end
        S_EVICT: if (mem_ack) begin
          beat <= beat + WSEL_W'(1);
          if (last) begin
            mod_q[a_idx] <= 1'b0;
            st           <= S_FILL;
          end
        end
        S_FILL: if (mem_ack) begin
          beat <= beat + WSEL_W'(1);
          if (last) begin
            vld_q[a_idx] <= 1'b1;
            mod_q[a_idx] <= 1'b0;
            again        <= 1'b1;
            st           <= S_LOOK;
          end
        end
        default: st <= S_LOOK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (fill_ack) dat_q[{a_idx, beat}] <= mem_rdata;
    else if (cpu_ready && cpu_we) dat_q[{a_idx, a_wsel}] <= cpu_wdata;
    if (fill_ack && last) tag_q[a_idx] <= a_tag;
  end
endmodule

// File: rtl/dm_wb_cache_chk.sv
module dm_wb_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 4,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic [CNT_W-1:0]  hit_count,
  input logic [CNT_W-1:0]  miss_count
);
  a_r4_ready_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !mem_req);
  a_r5_mem_only_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (cpu_req && !cpu_ready));
  a_r5_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  a_r1_fill_block: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_addr[ADDR_W-1:OFF_W] == cpu_addr[ADDR_W-1:OFF_W]));
  a_r6_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> mem_req);
  a_r9_miss_step: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (miss_count == $past(miss_count) || miss_count == $past(miss_count) + CNT_W'(1)));
  a_r9_hit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ready |=> $stable(hit_count));
endmodule

bind dm_wb_cache dm_wb_cache_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
  .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_ack(mem_ack), .hit_count(hit_count), .miss_count(miss_count)
);

// File: tb/sim_dm_wb_cache.sv
module sim_dm_wb_cache;
  localparam int LINES = 32;
  localparam int WPB   = 4;
  localparam int LAT   = 3;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [31:0] cpu_rdata, mem_addr, mem_wdata;
  logic        cpu_ready, mem_req, mem_we;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic [31:0] hit_count, miss_count;

  always #4 clk = ~clk;

  dm_wb_cache #(.LINES(LINES), .BLOCK_BYTES(16)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .hit_count(hit_count), .miss_count(miss_count)
  );

  logic [31:0] store   [0:4095];
  logic [31:0] ref_mem [0:4095];
  logic        m_vld [0:LINES-1];
  logic        m_mod [0:LINES-1];
  logic [22:0] m_tag [0:LINES-1];
  int lat_cnt = 0, wr_beats = 0, rd_beats = 0;
  logic [31:0] last_rd_addr = '0, last_wr_addr = '0;
  int total = 0, fails = 0, exp_hits = 0, exp_misses = 0;

  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (lat_cnt == LAT) begin
        lat_cnt = 0;
        mem_ack = 1'b1;
        if (mem_we) begin
          store[mem_addr[13:2]] = mem_wdata;
          last_wr_addr = mem_addr;
          wr_beats++;
        end else begin
          mem_rdata = store[mem_addr[13:2]];
          last_rd_addr = mem_addr;
          rd_beats++;
        end
      end else lat_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] idx_of(input logic [31:0] a); return a[8:4]; endfunction
  function automatic logic [22:0] tag_of(input logic [31:0] a); return a[31:9]; endfunction

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int stalls);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; stalls = 0;
    #1;
    while (!cpu_ready && stalls < 1000) begin
      @(negedge clk); #1; stalls++;
    end
    rd = cpu_rdata;
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  task automatic op(input logic we, input logic [31:0] a, input logic [31:0] wd);
    logic [31:0] rd;
    int stalls, wr0, rd0;
    bit p_hit;
    int p_wb;
    p_hit = m_vld[idx_of(a)] && m_tag[idx_of(a)] == tag_of(a);
    p_wb  = (!p_hit && m_vld[idx_of(a)] && m_mod[idx_of(a)]) ? WPB : 0;
    wr0 = wr_beats; rd0 = rd_beats;
    access(we, a, wd, rd, stalls);
    if (p_hit) exp_hits++; else exp_misses++;
    check((stalls == 0) == p_hit, "R2/R5 hit-vs-stall", stalls, p_hit ? 0 : 1);
    if (!we) check(rd == ref_mem[a[13:2]], "R3 load data", rd, ref_mem[a[13:2]]);
    check(wr_beats - wr0 == p_wb, p_hit ? "R4 no write on hit" : "R6/R5 write-back beats", wr_beats - wr0, p_wb);
    check(rd_beats - rd0 == (p_hit ? 0 : WPB), "R5 refill beats", rd_beats - rd0, p_hit ? 0 : WPB);
    if (!p_hit)
      check(last_rd_addr == {a[31:4], 4'hC}, "R1 refill address", last_rd_addr, {a[31:4], 4'hC});
    check(miss_count == exp_misses, "R9 miss_count", miss_count, exp_misses);
    check(hit_count == exp_hits, "R9 hit_count", hit_count, exp_hits);
    if (we) ref_mem[a[13:2]] = wd;
    if (!p_hit) m_mod[idx_of(a)] = 1'b0;
    if (we) m_mod[idx_of(a)] = 1'b1;
    m_vld[idx_of(a)] = 1'b1;
    m_tag[idx_of(a)] = tag_of(a);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int stalls;
    for (int i = 0; i < 4096; i++) begin
      store[i] = (i * 32'h9E3779B1) ^ 32'h5A5A0000;
      ref_mem[i] = store[i];
    end
    for (int i = 0; i < LINES; i++) begin m_vld[i] = 1'b0; m_mod[i] = 1'b0; m_tag[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    check(mem_req == 1'b0, "R8 idle mem_req", mem_req, 0);
    check(hit_count == 0, "R8 hit_count reset", hit_count, 0);
    check(miss_count == 0, "R8 miss_count reset", miss_count, 0);
    check(cpu_ready == 1'b0, "R8 ready without req", cpu_ready, 0);

    // R2 R5 R8: six-access pattern miss,hit,miss,miss,hit,hit
    op(0, 32'd1000, 0); op(0, 32'd1004, 0); op(0, 32'd1008, 0);
    op(0, 32'd2548, 0); op(0, 32'd2552, 0); op(0, 32'd2556, 0);
    check(exp_misses == 3 && exp_hits == 3, "R2 pattern totals", exp_misses, 3);

    // R1 high tag decode
    op(0, 32'h01FFF8AC, 0);
    op(0, 32'h01FFF8A0, 0);

    // R4 R7 store miss then store hit then eviction of dirty line
    op(1, 32'h00000100, 32'hCAFE0001);
    op(1, 32'h00000104, 32'hCAFE0002);
    op(0, 32'h00000100, 0);
    op(0, 32'h00000300, 0);
    check(store[32'h100 >> 2] == 32'hCAFE0001, "R6 written-back word 0", store[32'h100 >> 2], 32'hCAFE0001);
    check(store[32'h104 >> 2] == 32'hCAFE0002, "R6 written-back word 1", store[32'h104 >> 2], 32'hCAFE0002);
    check(last_wr_addr == 32'h0000010C, "R6 victim address", last_wr_addr, 32'h0000010C);
    op(0, 32'h00000104, 0);

    // R3 random mix
    void'($urandom(32'd2024));
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      logic w;
      a = ($urandom % 1024) << 2;
      w = ($urandom % 3) == 0;
      op(w, a, $urandom);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule